// File: doc/BRIEF.md
# Four-Phase Pipelined Instruction Sequencer

This block paces a small microcontroller core from a single oscillator input. It splits every instruction cycle into four oscillator periods, named phases one to four. Each phase has a fixed job: the program address steps forward at the end of phase one. Operands are read in phase two. Results are written in phase four. The next instruction word is latched at the end of phase four.

Fetch and execute overlap. One word is executed while the word after it is being fetched, so code without branches retires one instruction per instruction cycle. When the execute unit reports a taken jump, the word that was already prefetched is discarded and replaced by a no-operation. The next cycle fetches from the jump target, so a taken jump costs two instruction cycles.

The block contains the program counter, the fetch latch and the instruction register. Decoding, arithmetic, the register file and the return-address stack are outside it. The execute unit reads the instruction register, honours the read and write strobes, and returns a taken flag and a target address. A divided clock output lets neighbouring logic follow the instruction rate.

Top module: `quad_phase_sequencer`

## Requirements
- R1: `phaseStrobe` is one-hot at every oscillator cycle. It rotates bit 0 → bit 1 → bit 2 → bit 3 → bit 0 on each rising edge, where bit 0 is phase one and bit 3 is phase four.
- R2: While `rst` is high and in the cycle after it is released, `phaseStrobe` is 4'b0001, `progAddr` is 0 and `instrWord` equals the NOP word (all zeros by default). The first instruction cycle after reset fetches address 0, presents NOP and raises no write strobe.
- R3: `progAddr` changes only at the rising edge that ends phase one. If no jump was taken in the previous cycle, it becomes the previous value plus one. It then holds through phases two, three and four and the next phase one.
- R4: The word on `progWord` at the end of phase four is captured. At the end of the next phase one it appears on `instrWord`, which then holds until the following phase-one edge.
- R5: `opndRead` is high exactly during phase two of every instruction cycle.
- R6: `destWrite` is high during phase four, except in a cycle whose instruction was flushed. It is never high in any other phase.
- R7: A `branchTaken` that is high at the end of phase four in a cycle that was not flushed has two effects. In the next instruction cycle `progAddr` equals the `branchTarget` sampled at that edge, and `instrWord` is NOP.
- R8: A `branchTaken` during a flushed cycle is ignored: the next cycle fetches the sequential address.
- R9: `branchTaken` pulses that fall before the end of phase four have no effect on `progAddr` or `instrWord`.
- R10: `cycleClk` is high during phases two and three and low during phases four and one.
- R11: The program address wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock, four periods per instruction cycle |
| rst | input | 1 | Asynchronous active-high reset |
| progWord | input | INSTR_W | Instruction word read from program memory at `progAddr` |
| branchTaken | input | 1 | Execute unit reports a taken jump, sampled at the end of phase four |
| branchTarget | input | ADDR_W | Jump destination, sampled together with `branchTaken` |
| progAddr | output | ADDR_W | Program counter, used as the program-memory address |
| instrWord | output | INSTR_W | Instruction register, the word being executed |
| phaseStrobe | output | 4 | One-hot phase indicator, bit 0 = phase one |
| opndRead | output | 1 | Data-memory operand read strobe |
| destWrite | output | 1 | Data-memory destination write strobe |
| cycleClk | output | 1 | Instruction-rate clock, one quarter of the oscillator rate |

## Verification
The first stimulus is straight-line code. A program memory whose words are a function of their address shows that each executed word is the one fetched one cycle earlier, and that the address moves by exactly one per cycle.

Directed cycles then cover four cases:
- a taken jump, to show that the flush inserts a NOP;
- a jump requested inside the flushed cycle, to tell it apart from a jump that takes effect;
- a short pulse that ends before phase four, to show that only the sampled edge counts;
- a jump to the all-ones address, to exercise the wrap to zero.

Random cycles mix these cases, including back-to-back jumps. The phase, read, write and clock-out strobes are checked in every phase of every cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    PH_ONE   = 2'd0,
    PH_TWO   = 2'd1,
    PH_THREE = 2'd2,
    PH_FOUR  = 2'd3
  } phase_e;

  // Per-phase commands from the control to the datapath.
  typedef struct packed {
    logic loadIr;        // end of phase one: advance PC, move latch into IR
    logic captureFetch;  // end of phase four: latch fetched word, sample jump
  } seq_strobes_t;

endpackage

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import seq_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic              oscClk,
  input  logic              rst,
  input  logic              flushActive,
  output seq_strobes_t      strobes,
  output logic [PHASES-1:0] phaseStrobe,
  output logic              opndRead,
  output logic              destWrite,
  output logic              cycleClk
);

  phase_e phaseQ;

  always_ff @(posedge oscClk or posedge rst) begin
    if (rst) begin
      phaseQ <= PH_ONE;
    end else begin
      unique case (phaseQ)
        PH_ONE:   phaseQ <= PH_TWO;
        PH_TWO:   phaseQ <= PH_THREE;
        PH_THREE: phaseQ <= PH_FOUR;
        default:  phaseQ <= PH_ONE;
      endcase
    end
  end

  // One-hot decode of the phase counter.
  for (genvar i = 0; i < PHASES; i++) begin : g_phaseDecode
    assign phaseStrobe[i] = (phaseQ == phase_e'(i));
  end

  always_comb begin
    strobes              = '0;
    strobes.loadIr       = (phaseQ == PH_ONE);
    strobes.captureFetch = (phaseQ == PH_FOUR);
  end

  assign opndRead  = (phaseQ == PH_TWO);
  assign destWrite = (phaseQ == PH_FOUR) && !flushActive;
  assign cycleClk  = (phaseQ == PH_TWO) || (phaseQ == PH_THREE);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int              ADDR_W   = 11,
  parameter int              INSTR_W  = 14,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0,
  parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
  input  logic               oscClk,
  input  logic               rst,
  input  seq_strobes_t       strobes,
  input  logic [INSTR_W-1:0] progWord,
  input  logic               branchTaken,
  input  logic [ADDR_W-1:0]  branchTarget,
  output logic [ADDR_W-1:0]  progAddr,
  output logic [INSTR_W-1:0] instrWord,
  output logic               flushActive
);

  logic [ADDR_W-1:0]  pcQ;
  logic [ADDR_W-1:0]  pendTargetQ;
  logic               pendTakenQ;
  logic [INSTR_W-1:0] fetchLatchQ;
  logic [INSTR_W-1:0] irQ;
  logic               flushQ;

  // End of phase four: latch the prefetched word, sample the jump request.
  // A flushed cycle carries no real instruction, so its jump is dropped.
  // Reset arms a pending jump to RESET_PC so the first cycle is a flush.
  always_ff @(posedge oscClk or posedge rst) begin
    if (rst) begin
      fetchLatchQ <= NOP_WORD;
      pendTakenQ  <= 1'b1;
      pendTargetQ <= RESET_PC;
    end else if (strobes.captureFetch) begin
      fetchLatchQ <= progWord;
      pendTakenQ  <= branchTaken && !flushQ;
      pendTargetQ <= branchTarget;
    end
  end

  // End of phase one: step or redirect the PC and fill the IR.
  always_ff @(posedge oscClk or posedge rst) begin
    if (rst) begin
      pcQ    <= RESET_PC;
      irQ    <= NOP_WORD;
      flushQ <= 1'b1;
    end else if (strobes.loadIr) begin
      if (pendTakenQ) begin
        pcQ    <= pendTargetQ;
        irQ    <= NOP_WORD;
        flushQ <= 1'b1;
      end else begin
        pcQ    <= pcQ + 1'b1;
        irQ    <= fetchLatchQ;
        flushQ <= 1'b0;
      end
    end
  end

  assign progAddr    = pcQ;
  assign instrWord   = irQ;
  assign flushActive = flushQ;

endmodule

// File: rtl/quad_phase_sequencer.sv
module quad_phase_sequencer
  import seq_pkg::*;
#(
  parameter int                 ADDR_W   = 11,
  parameter int                 INSTR_W  = 14,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               oscClk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] progWord,
  input  logic               branchTaken,
  input  logic [ADDR_W-1:0]  branchTarget,
  output logic [ADDR_W-1:0]  progAddr,
  output logic [INSTR_W-1:0] instrWord,
  output logic [3:0]         phaseStrobe,
  output logic               opndRead,
  output logic               destWrite,
  output logic               cycleClk
);

  localparam int PHASES = 4;

  seq_strobes_t strobes;
  logic         flushActive;

  seq_phase_ctrl #(
    .PHASES(PHASES)
  ) u_ctrl (
    .oscClk     (oscClk),
    .rst        (rst),
    .flushActive(flushActive),
    .strobes    (strobes),
    .phaseStrobe(phaseStrobe),
    .opndRead   (opndRead),
    .destWrite  (destWrite),
    .cycleClk   (cycleClk)
  );

  seq_datapath #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W),
    .NOP_WORD(NOP_WORD),
    .RESET_PC('0)
  ) u_dp (
    .oscClk      (oscClk),
    .rst         (rst),
    .strobes     (strobes),
    .progWord    (progWord),
    .branchTaken (branchTaken),
    .branchTarget(branchTarget),
    .progAddr    (progAddr),
    .instrWord   (instrWord),
    .flushActive (flushActive)
  );

endmodule

// File: rtl/quad_phase_sequencer_chk.sv
module quad_phase_sequencer_chk #(
  parameter int                 ADDR_W   = 11,
  parameter int                 INSTR_W  = 14,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input logic               oscClk,
  input logic               rst,
  input logic               branchTaken,
  input logic [ADDR_W-1:0]  branchTarget,
  input logic [ADDR_W-1:0]  progAddr,
  input logic [INSTR_W-1:0] instrWord,
  input logic [3:0]         phaseStrobe,
  input logic               opndRead,
  input logic               destWrite,
  input logic               cycleClk
);

  a_r1_onehot: assert property (@(posedge oscClk) disable iff (rst)
    $countones(phaseStrobe) == 1);

  a_r1_rotate: assert property (@(posedge oscClk) disable iff (rst)
    1'b1 |=> phaseStrobe == {$past(phaseStrobe[2:0]), $past(phaseStrobe[3])});

  a_r3_addr_hold: assert property (@(posedge oscClk) disable iff (rst)
    !phaseStrobe[0] |=> $stable(progAddr));

  a_r4_ir_hold: assert property (@(posedge oscClk) disable iff (rst)
    !phaseStrobe[0] |=> $stable(instrWord));

  a_r5_read_then_three: assert property (@(posedge oscClk) disable iff (rst)
    opndRead |=> phaseStrobe[2]);

  a_r6_write_phase: assert property (@(posedge oscClk) disable iff (rst)
    destWrite |=> phaseStrobe[0]);

  // R7: a jump in a live cycle redirects the fetch and inserts NOP
  a_r7_redirect: assert property (@(posedge oscClk) disable iff (rst)
    phaseStrobe[3] && destWrite && branchTaken |->
      ##2 (progAddr == $past(branchTarget, 2) && instrWord == NOP_WORD));

  // R3/R8: without a live jump the address steps by one
  a_r8_sequential: assert property (@(posedge oscClk) disable iff (rst)
    phaseStrobe[3] && !(destWrite && branchTaken) |->
      ##2 (progAddr == ADDR_W'($past(progAddr, 2) + 1'b1)));

  a_r10_clk_rise: assert property (@(posedge oscClk) disable iff (rst)
    $rose(cycleClk) |-> phaseStrobe[1]);

  a_r10_clk_fall: assert property (@(posedge oscClk) disable iff (rst)
    $fell(cycleClk) |-> phaseStrobe[3]);

endmodule

bind quad_phase_sequencer quad_phase_sequencer_chk #(
  .ADDR_W  (ADDR_W),
  .INSTR_W (INSTR_W),
  .NOP_WORD(NOP_WORD)
) u_chk (
  .oscClk      (oscClk),
  .rst         (rst),
  .branchTaken (branchTaken),
  .branchTarget(branchTarget),
  .progAddr    (progAddr),
  .instrWord   (instrWord),
  .phaseStrobe (phaseStrobe),
  .opndRead    (opndRead),
  .destWrite   (destWrite),
  .cycleClk    (cycleClk)
);

// File: tb/test_quad_phase_sequencer.sv
`timescale 1ns/1ps
module test_quad_phase_sequencer;

  localparam int AW = 11;
  localparam int IW = 14;
  localparam logic [IW-1:0] NOPW = '0;

  logic          oscClk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] progWord;
  logic          branchTaken = 1'b0;
  logic [AW-1:0] branchTarget = '0;
  logic [AW-1:0] progAddr;
  logic [IW-1:0] instrWord;
  logic [3:0]    phaseStrobe;
  logic          opndRead, destWrite, cycleClk;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Model state: the pending jump and the last fetch address.
  bit            mPend = 1'b1;
  logic [AW-1:0] mTgt = '0;
  logic [AW-1:0] mFetch = '0;
  logic [IW-1:0] mIr = '0;
  bit            mFlush = 1'b1;
  string         mWhy = "R2";

  always #2.5 oscClk = ~oscClk;

  // Program memory contents as a function of the address; never NOP.
  function automatic logic [IW-1:0] memWord(input logic [AW-1:0] a);
    return (IW'(a) * 14'd91 + 14'd7) | 14'h2000;
  endfunction

  assign progWord = memWord(progAddr);

  quad_phase_sequencer i_quad_phase_sequencer (
    .oscClk(oscClk), .rst(rst), .progWord(progWord),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .progAddr(progAddr), .instrWord(instrWord), .phaseStrobe(phaseStrobe),
    .opndRead(opndRead), .destWrite(destWrite), .cycleClk(cycleClk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at the falling edge inside phase one; leaves at the next one.
  task automatic runCycle(input bit br, input bit glitch, input logic [AW-1:0] tgt);
    logic [AW-1:0] prevFetch;
    check("R1 phase one", 32'(phaseStrobe), 32'h1);
    check("R10 clk low in one", 32'(cycleClk), 32'h0);
    check("R6 no write in one", 32'(destWrite), 32'h0);
    prevFetch = mFetch;
    if (mPend) begin
      mFetch = mTgt; mIr = NOPW; mFlush = 1'b1;
    end else begin
      mIr = memWord(prevFetch); mFetch = prevFetch + 1'b1; mFlush = 1'b0;
      if (mFetch == '0) mWhy = "R11";
    end
    @(negedge oscClk); // phase two
    check("R1 phase two", 32'(phaseStrobe), 32'h2);
    check({mWhy, " fetch address"}, 32'(progAddr), 32'(mFetch));
    check({mWhy, " R4 instruction"}, 32'(instrWord), 32'(mIr));
    check("R5 read in two", 32'(opndRead), 32'h1);
    check("R10 clk high in two", 32'(cycleClk), 32'h1);
    check("R6 no write in two", 32'(destWrite), 32'h0);
    if (br || glitch) begin
      branchTaken = 1'b1; branchTarget = tgt;
    end
    @(negedge oscClk); // phase three
    check("R1 phase three", 32'(phaseStrobe), 32'h4);
    check("R5 no read in three", 32'(opndRead), 32'h0);
    check("R10 clk high in three", 32'(cycleClk), 32'h1);
    check("R3 address holds", 32'(progAddr), 32'(mFetch));
    if (glitch) branchTaken = 1'b0;
    @(negedge oscClk); // phase four
    check("R1 phase four", 32'(phaseStrobe), 32'h8);
    check(mFlush ? "R6 flushed write off" : "R6 write in four", 32'(destWrite), 32'(!mFlush));
    check("R10 clk low in four", 32'(cycleClk), 32'h0);
    check("R4 IR holds", 32'(instrWord), 32'(mIr));
    @(negedge oscClk); // next phase one
    branchTaken = 1'b0;
    check("R3 address holds in one", 32'(progAddr), 32'(mFetch));
    mPend = br && !glitch && !mFlush;
    mTgt  = tgt;
    if (mPend)               mWhy = "R7";
    else if (br && mFlush)   mWhy = "R8";
    else if (glitch)         mWhy = "R9";
    else                     mWhy = "R3";
  endtask

  initial begin
    repeat (3) @(posedge oscClk);
    check("R2 reset phase", 32'(phaseStrobe), 32'h1);
    check("R2 reset address", 32'(progAddr), 32'h0);
    check("R2 reset IR", 32'(instrWord), 32'(NOPW));
    @(negedge oscClk);
    rst = 1'b0;
    check("R2 phase after release", 32'(phaseStrobe), 32'h1);
    check("R2 address after release", 32'(progAddr), 32'h0);
    check("R2 IR after release", 32'(instrWord), 32'(NOPW));
    // Directed corner cases.
    for (int i = 0; i < 4; i++) runCycle(1'b0, 1'b0, '0);
    runCycle(1'b1, 1'b0, 11'h123);    // R7 taken jump
    runCycle(1'b1, 1'b0, 11'h0AA);    // R8 jump inside flush
    for (int i = 0; i < 3; i++) runCycle(1'b0, 1'b0, '0);
    runCycle(1'b0, 1'b1, 11'h555);    // R9 early pulse
    runCycle(1'b0, 1'b0, '0);
    runCycle(1'b1, 1'b0, 11'h7FF);    // R11 wrap setup
    for (int i = 0; i < 3; i++) runCycle(1'b0, 1'b0, '0);
    runCycle(1'b1, 1'b0, 11'h7FE);
    for (int i = 0; i < 4; i++) runCycle(1'b0, 1'b0, '0);
    // Random mix with a fixed seed.
    void'($urandom(32'h5eed_0715));
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 100;
      runCycle(r < 25, (r >= 25) && (r < 33), AW'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge oscClk);
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule